// File: doc/BRIEF.md
# Variable-Delay Response Checker

This block is a synthesizable run-time monitor for a handshake in which a response must follow a trigger after a fixed number of clock cycles, where that number is set by a small delay input that may change while the system runs. When the trigger rises, the monitor stores the delay that is present on that cycle. It then checks that the response stays low while it waits and rises on exactly the expected cycle.

The monitor reports each verdict as a one-cycle pulse. A pass pulse marks a response edge that arrived on time. A fail pulse marks one of three faults: the response went high too early, it did not rise when expected, or it rose late. An early response is reported on the cycle it appears, and a missing edge is reported on the expected cycle, so the monitor never waits without limit. A busy output shows when a check is active. Only one check is tracked at a time. A disable input abandons the active check and suppresses all verdicts while it is high.

Top module: `resp_latency_monitor`

## Requirements
- R1: A rising edge of the trigger starts a check. This means the trigger is high on a cycle, was low on the cycle before, no check is active, and disable is low. Busy is high from the next cycle through the evaluation cycle.
- R2: The delay input is captured on the trigger cycle. Changes to the delay input during a check have no effect on that check.
- R3: With a captured delay D of 2 or more, the response must be low on cycles 1 to D-1 after the trigger. If it is high on any of those cycles, fail pulses on that same cycle and busy is low on the next cycle.
- R4: If the response is low on cycle D-1 (or on the trigger cycle when D is 1) and high on cycle D, pass pulses on cycle D.
- R5: A captured delay of 0 is treated exactly like a delay of 1, so the response must rise on the cycle right after the trigger.
- R6: If the response has no rising edge on cycle D, fail pulses on cycle D and the check ends. This covers a response that stays low, a late response, and a response that is already high.
- R7: While disable is high, pass and fail stay low and no new check starts. A check that was active is dropped, and busy is low from the next cycle.
- R8: A trigger rising edge that arrives while a check is active is ignored. The active check ends at its own evaluation cycle.
- R9: Synchronous reset clears busy, the counter and the stored previous trigger and response values. As a result, a trigger that is high on the first cycle after reset counts as a rising edge.
- R10: Pass and fail are never high together, and each lasts at most one cycle per check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_off | input | 1 | Disable; abandons and suppresses checks while high |
| trig | input | 1 | Trigger signal |
| resp | input | 1 | Response signal |
| dly | input | DLY_W (4) | Expected latency in cycles, 0 treated as 1 |
| pass | output | 1 | One-cycle pulse: response rose on time |
| fail | output | 1 | One-cycle pulse: early, late or missing response |
| busy | output | 1 | A check is active |

## Verification
The bound assertions check the following on every cycle: pass and fail are never high together, each verdict pulse lasts one cycle, an early response gives fail at once, a missed edge at the final count gives fail, disable silences all verdicts, and a check stays active until its evaluation cycle. The bench's scenarios show the behaviours that depend on the delay value itself. These are the on-time pass for several delays including 0 and 15, the delay latched at the trigger while the input changes afterwards, late and already-high responses, a retrigger while busy, and a trigger held high across reset release. A behavioural model counts cycles upward and compares pass, fail and busy on every clock.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  // Effective wait length: a zero delay behaves as a one-cycle delay.
  function automatic int unsigned eff_delay(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Counter value at which the response is evaluated.
  localparam int unsigned FINAL_COUNT = 1;

  // Early response: high while still inside the waiting window.
  function automatic logic is_early(input logic active, input logic last_cyc,
                                    input logic r);
    return active && !last_cyc && r;
  endfunction

endpackage

// File: rtl/rlm_edge.sv
module rlm_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign rise = sig && !prev_q;
endmodule

// File: rtl/rlm_window.sv
module rlm_window #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off,
  input  logic             start,
  input  logic             stop,
  input  logic [DLY_W-1:0] dly,
  output logic             active,
  output logic             last_cyc
);
  localparam int CNT_W = DLY_W;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(rlm_pkg::eff_delay(32'(dly)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (off) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (stop) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end
  end

  assign active   = busy_q;
  assign last_cyc = busy_q && (cnt_q == CNT_W'(rlm_pkg::FINAL_COUNT));
endmodule

// File: rtl/rlm_verdict.sv
module rlm_verdict (
  input  logic off,
  input  logic active,
  input  logic last_cyc,
  input  logic resp,
  input  logic resp_rise,
  output logic pass,
  output logic fail
);
  logic early;
  logic on_time;

  always_comb begin
    early   = rlm_pkg::is_early(active, last_cyc, resp);
    on_time = active && last_cyc && resp_rise;
    pass    = !off && on_time;
    fail    = !off && (early || (last_cyc && !resp_rise));
  end
endmodule

// File: rtl/resp_latency_monitor.sv
module resp_latency_monitor #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_off,
  input  logic             trig,
  input  logic             resp,
  input  logic [DLY_W-1:0] dly,
  output logic             pass,
  output logic             fail,
  output logic             busy
);
  logic trig_rise;
  logic resp_rise;
  logic start_chk;
  logic at_final;
  logic verdict;

  rlm_edge u_trig_edge (.clk(clk), .rst(rst), .sig(trig), .rise(trig_rise));
  rlm_edge u_resp_edge (.clk(clk), .rst(rst), .sig(resp), .rise(resp_rise));

  assign start_chk = trig_rise && !busy && !mon_off;
  assign verdict   = pass || fail;

  rlm_window #(.DLY_W(DLY_W)) u_window (
    .clk(clk), .rst(rst), .off(mon_off), .start(start_chk), .stop(verdict),
    .dly(dly), .active(busy), .last_cyc(at_final)
  );

  rlm_verdict u_verdict (
    .off(mon_off), .active(busy), .last_cyc(at_final), .resp(resp),
    .resp_rise(resp_rise), .pass(pass), .fail(fail)
  );
endmodule

// File: rtl/rlm_checker.sv
module rlm_checker (
  input logic clk,
  input logic rst,
  input logic mon_off,
  input logic resp,
  input logic resp_rise,
  input logic start_chk,
  input logic at_final,
  input logic pass,
  input logic fail,
  input logic busy
);
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_chk |=> busy);

  p_early_fail_r3: assert property (@(posedge clk) disable iff (rst || mon_off)
    (busy && !at_final && resp) |-> fail);

  p_verdict_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |=> !busy);

  p_miss_fail_r6: assert property (@(posedge clk) disable iff (rst || mon_off)
    (at_final && !resp_rise) |-> fail);

  p_silent_off_r7: assert property (@(posedge clk) disable iff (rst)
    mon_off |-> (!pass && !fail));

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst || mon_off)
    (busy && !at_final && !resp) |=> busy);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |=> (!pass && !fail));
endmodule

bind resp_latency_monitor rlm_checker u_rlm_checker (
  .clk(clk), .rst(rst), .mon_off(mon_off), .resp(resp),
  .resp_rise(resp_rise), .start_chk(start_chk), .at_final(at_final),
  .pass(pass), .fail(fail), .busy(busy)
);

// File: tb/test_resp_latency_monitor.sv
module test_resp_latency_monitor;
  logic       clk = 1'b0;
  logic       rst, mon_off, trig, resp;
  logic [3:0] dly;
  logic       pass, fail, busy;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R9";
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  int pass_seen = 0;
  int fail_seen = 0;

  // model state
  bit m_busy = 0;
  int m_elapsed = 0;
  int m_target = 0;
  bit m_prev_t = 0;
  bit m_prev_r = 0;

  always #5 clk = ~clk;

  resp_latency_monitor i_resp_latency_monitor (
    .clk(clk), .rst(rst), .mon_off(mon_off), .trig(trig), .resp(resp),
    .dly(dly), .pass(pass), .fail(fail), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: counts cycles upward since the trigger.
  always @(negedge clk) begin
    bit e_pass, e_fail;
    e_pass = 0; e_fail = 0;
    if (m_busy && !mon_off) begin
      if (m_elapsed < m_target) e_fail = resp;
      else begin
        e_pass = resp && !m_prev_r;
        e_fail = !e_pass;
      end
    end
    if (chk_en) begin
      check(cur_req, int'(busy), int'(m_busy), "busy");
      check(cur_req, int'(pass), int'(e_pass), "pass");
      check(cur_req, int'(fail), int'(e_fail), "fail");
    end
    if (pass) pass_seen++;
    if (fail) fail_seen++;
    if (rst) begin
      m_busy = 0; m_elapsed = 0; m_prev_t = 0; m_prev_r = 0;
    end else begin
      if (mon_off) m_busy = 0;
      else if (m_busy) begin
        if (e_pass || e_fail) m_busy = 0;
        else m_elapsed++;
      end else if (trig && !m_prev_t) begin
        m_busy = 1;
        m_elapsed = 1;
        m_target = (dly == 0) ? 1 : int'(dly);
      end
      m_prev_t = trig;
      m_prev_r = resp;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // One trial: trigger on cycle 0, then cycles 1..span.
  task automatic trial(input string req, input int d, input int rise_at,
                       input int off_at, input int retrig_at,
                       input int exp_pass, input int exp_fail);
    int span;
    int p0, f0;
    cur_req = req;
    span = ((d == 0) ? 1 : d) + 2;
    p0 = pass_seen; f0 = fail_seen;
    trig = 1; dly = 4'(d); resp = (rise_at == 0); mon_off = 0;
    tick();
    for (int k = 1; k <= span; k++) begin
      trig = (k == retrig_at);
      dly = 4'(~d);
      resp = (rise_at >= 0) && (k >= rise_at);
      mon_off = (k == off_at);
      tick();
    end
    trig = 0; resp = 0; mon_off = 0;
    repeat (3) tick();
    check(req, pass_seen - p0, exp_pass, "pass pulses");
    check(req, fail_seen - f0, exp_fail, "fail pulses");
  endtask

  initial begin
    rst = 1; mon_off = 0; trig = 1; resp = 0; dly = 4'd2;
    repeat (3) tick();
    chk_en = 1;
    check("R9", int'(busy), 0, "busy in reset");
    rst = 0;
    tick();
    // R9: trigger held high across reset release counts as a rise
    check("R9", int'(busy), 1, "busy after release");
    trig = 0;
    repeat (5) tick();
    trial("R4", 6, 6, -1, -1, 1, 0);
    trial("R1", 1, 1, -1, -1, 1, 0);
    trial("R5", 0, 1, -1, -1, 1, 0);
    trial("R2", 3, 3, -1, -1, 1, 0);
    trial("R3", 5, 2, -1, -1, 0, 1);
    trial("R6", 4, -1, -1, -1, 0, 1);
    trial("R6", 2, 3, -1, -1, 0, 1);
    trial("R6", 1, 0, -1, -1, 0, 1);
    trial("R7", 4, 4, 2, -1, 0, 0);
    trial("R8", 5, 5, -1, 2, 1, 0);
    trial("R4", 15, 15, -1, -1, 1, 0);
    trial("R10", 3, 3, -1, -1, 1, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule